// File: doc/BRIEF.md
# Scheduled Square-Wave Pin Generator

This block drives one output pin with a square wave of 50% duty cycle whose edges are placed on an absolute 64-bit time counter. Software loads a 64-bit start time and a 32-bit half-period, both counted in ticks of the time counter (8 ns per tick in the intended system). It then issues a start command. The generator waits until the counter reaches the start time, raises the pin, and from then on toggles it each time the counter reaches the previous edge time plus the half-period. The output frequency is therefore 1e9 / (half_period × 8 ns × 2). The 32-bit half-period allows periods up to about 68.7 s.

Edges are scheduled from the previous scheduled edge, not from the moment the toggle was seen. The phase therefore does not drift. Each edge fires on a greater-or-equal comparison, so a counter that jumps forward past one or more edges still produces those toggles, at most one per cycle. A start command is accepted only when the programmed start time lies strictly after the counter value in the command cycle. Otherwise the command is dropped. A stop command disarms the generator and returns the pin low at once. Only one channel exists.

Top module: `sched_square_out`

## Requirements
- R1: While and after reset, the pin is low and the generator is disarmed.
- R2: A command write with bit 28 set (start) and bit 27 clear, whose stored start time is greater than the counter in that cycle, arms the generator. The pin rises in the cycle after the first clock edge at which the counter is greater than or equal to the start time.
- R3: A start command whose stored start time is less than or equal to the counter in that cycle has no effect: the pin stays low and no edge follows.
- R4: Once running, each further edge is due at the previous due time plus the half-period. The pin toggles one cycle after the counter first reaches the due time, which gives a 50% duty cycle.
- R5: If the counter jumps past one or more due times, the pin toggles once per cycle, in every cycle where the counter is at or beyond the current due time. Each due time still advances by exactly one half-period, so the phase is kept.
- R6: A command write with bit 27 set (stop) forces the pin low on the next cycle and disarms the generator. When bits 27 and 28 are both set, stop takes precedence and the start is not taken.
- R7: The half-period uses all 32 bits (up to 0xFFFF_FFFF ticks), and due times are computed in the full 64-bit width.
- R8: Writes to the start-time or half-period registers without a command do not change the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_i | input | 64 | Current value of the time counter, in ticks |
| start_wr_i | input | 1 | Write strobe for the start-time register |
| start_val_i | input | 64 | Start time to store |
| half_wr_i | input | 1 | Write strobe for the half-period register |
| half_val_i | input | 32 | Half-period in ticks to store |
| cmd_wr_i | input | 1 | Command word strobe |
| cmd_word_i | input | 32 | Command word: bit 28 start, bit 27 stop |
| pin_o | output | 1 | Registered square-wave output |

## Verification
The assertions assume that the time counter only moves forward, by one tick per cycle or by a forward jump, and that it never wraps within a run. They also assume that register writes and commands use single-cycle strobes. The bench drives the counter as a bench-owned value that always increases, with explicit forward jumps for the add-mode case. It keeps every stop or start command off cycles where an edge is due, so that each expected toggle has a single outcome. Half-periods stay nonzero and start times stay far from the 64-bit limit, which keeps the due-time sums free of overflow.

// File: rtl/ppo_pkg.sv
package ppo_pkg;
  localparam int CMD_START_BIT = 28;
  localparam int CMD_STOP_BIT  = 27;

  typedef struct packed {
    logic go;
    logic halt;
  } ppo_cmd_t;
endpackage

// File: rtl/ppo_cfg_regs.sv
module ppo_cfg_regs #(
  parameter int TIME_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_wr,
  input  logic [TIME_W-1:0] start_val,
  input  logic              half_wr,
  input  logic [HALF_W-1:0] half_val,
  output logic [TIME_W-1:0] start_q,
  output logic [HALF_W-1:0] half_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      half_q  <= '0;
    end else begin
      if (start_wr) start_q <= start_val;
      if (half_wr)  half_q  <= half_val;
    end
  end

  assert_hold_start_R8: assert property (@(posedge clk) disable iff (rst)
    !start_wr |=> $stable(start_q));
  assert_hold_half_R8: assert property (@(posedge clk) disable iff (rst)
    !half_wr |=> $stable(half_q));
endmodule

// File: rtl/ppo_cmd_decode.sv
module ppo_cmd_decode
  import ppo_pkg::*;
#(
  parameter int CMD_W     = 32,
  parameter int START_POS = CMD_START_BIT,
  parameter int STOP_POS  = CMD_STOP_BIT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_word,
  output ppo_cmd_t         cmd
);
  // stop outranks start when both bits are present
  always_comb begin
    cmd.halt = cmd_wr & cmd_word[STOP_POS];
    cmd.go   = cmd_wr & cmd_word[START_POS] & ~cmd_word[STOP_POS];
  end

  assert_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(cmd.go && cmd.halt));
  assert_strobe_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd.go || cmd.halt) |-> cmd_wr);
endmodule

// File: rtl/ppo_edge_sched.sv
module ppo_edge_sched
  import ppo_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int HALF_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now,
  input  logic [TIME_W-1:0] start_t,
  input  logic [HALF_W-1:0] half_t,
  input  ppo_cmd_t          cmd,
  output logic              pin
);
  localparam int PAD_W = TIME_W - HALF_W;

  logic              armed_q;
  logic              pin_q;
  logic [TIME_W-1:0] due_q;
  logic [TIME_W-1:0] half_ext;
  logic              start_ok;
  logic              due_hit;

  always_comb begin
    half_ext = {{PAD_W{1'b0}}, half_t};
    start_ok = start_t > now;
    due_hit  = armed_q && (now >= due_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      pin_q   <= 1'b0;
      due_q   <= '0;
    end else if (cmd.halt) begin
      armed_q <= 1'b0;
      pin_q   <= 1'b0;
    end else if (cmd.go && start_ok) begin
      armed_q <= 1'b1;
      pin_q   <= 1'b0;
      due_q   <= start_t;
    end else if (due_hit) begin
      pin_q <= ~pin_q;
      due_q <= due_q + half_ext;
    end
  end

  assign pin = pin_q;

  assert_reset_low_R1: assert property (@(posedge clk)
    rst |=> (!pin_q && !armed_q));
  assert_arm_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd.go && !cmd.halt && start_t > now) |=> (armed_q && !pin_q && due_q == $past(start_t)));
  assert_reject_R3: assert property (@(posedge clk) disable iff (rst)
    (cmd.go && !armed_q && start_t <= now) |=> (!armed_q && !pin_q));
  assert_toggle_source_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(pin_q) |-> ($past(armed_q) || $past(cmd.halt)));
  assert_catch_up_R5: assert property (@(posedge clk) disable iff (rst)
    (armed_q && now >= due_q && !cmd.go && !cmd.halt) |=> (pin_q != $past(pin_q) && due_q == $past(due_q) + $past(half_ext)));
  assert_stop_low_R6: assert property (@(posedge clk) disable iff (rst)
    cmd.halt |=> (!pin_q && !armed_q));
endmodule

// File: rtl/sched_square_out.sv
module sched_square_out
  import ppo_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int HALF_W = 32,
  parameter int CMD_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TIME_W-1:0] now_i,
  input  logic              start_wr_i,
  input  logic [TIME_W-1:0] start_val_i,
  input  logic              half_wr_i,
  input  logic [HALF_W-1:0] half_val_i,
  input  logic              cmd_wr_i,
  input  logic [CMD_W-1:0]  cmd_word_i,
  output logic              pin_o
);
  logic [TIME_W-1:0] start_q;
  logic [HALF_W-1:0] half_q;
  ppo_cmd_t          cmd;

  ppo_cfg_regs #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .start_wr  (start_wr_i),
    .start_val (start_val_i),
    .half_wr   (half_wr_i),
    .half_val  (half_val_i),
    .start_q   (start_q),
    .half_q    (half_q)
  );

  ppo_cmd_decode #(.CMD_W(CMD_W)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .cmd_wr   (cmd_wr_i),
    .cmd_word (cmd_word_i),
    .cmd      (cmd)
  );

  ppo_edge_sched #(.TIME_W(TIME_W), .HALF_W(HALF_W)) u_sched (
    .clk     (clk),
    .rst     (rst),
    .now     (now_i),
    .start_t (start_q),
    .half_t  (half_q),
    .cmd     (cmd),
    .pin     (pin_o)
  );
endmodule

// File: tb/tb_sched_square_out.sv
module tb_sched_square_out;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] W_START = 32'h1000_0000;
  localparam logic [31:0] W_STOP  = 32'h0800_0000;
  localparam logic [31:0] W_BOTH  = 32'h1800_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] now_i = '0;
  logic        start_wr_i = 1'b0;
  logic [63:0] start_val_i = '0;
  logic        half_wr_i = 1'b0;
  logic [31:0] half_val_i = '0;
  logic        cmd_wr_i = 1'b0;
  logic [31:0] cmd_word_i = '0;
  logic        pin_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [63:0] q_time[$];
  logic        q_lvl[$];
  string       q_req[$];
  logic        last_pin = 1'b0;
  logic [63:0] et;
  logic        el;
  string       er;

  always #(CLK_PERIOD/2) clk = ~clk;

  sched_square_out dut (
    .clk(clk), .rst(rst), .now_i(now_i),
    .start_wr_i(start_wr_i), .start_val_i(start_val_i),
    .half_wr_i(half_wr_i), .half_val_i(half_val_i),
    .cmd_wr_i(cmd_wr_i), .cmd_word_i(cmd_word_i),
    .pin_o(pin_o)
  );

  // monitor: every pin change is matched against the scoreboard queue
  always @(posedge clk) begin
    #1;
    if (!rst && pin_o !== last_pin) begin
      checks++;
      if (q_time.size() == 0) begin
        fails++;
        $display("FAIL R4: unexpected edge at t=%0d level=%0b, expected no edge", now_i, pin_o);
      end else begin
        et = q_time.pop_front();
        el = q_lvl.pop_front();
        er = q_req.pop_front();
        if (et !== now_i || el !== pin_o) begin
          fails++;
          $display("FAIL %s: edge at t=%0d level=%0b, expected t=%0d level=%0b", er, now_i, pin_o, et, el);
        end
      end
      last_pin = pin_o;
    end
  end

  task automatic expect_edge(input logic [63:0] t, input logic lvl, input string req);
    q_time.push_back(t);
    q_lvl.push_back(lvl);
    q_req.push_back(req);
  endtask

  task automatic drive(input logic [63:0] t, input logic sw, input logic [63:0] sv,
                       input logic hw, input logic [31:0] hv,
                       input logic cw, input logic [31:0] cv);
    @(negedge clk);
    now_i = t; start_wr_i = sw; start_val_i = sv;
    half_wr_i = hw; half_val_i = hv; cmd_wr_i = cw; cmd_word_i = cv;
  endtask

  task automatic idle(input logic [63:0] t);
    drive(t, 1'b0, 64'd0, 1'b0, 32'd0, 1'b0, 32'd0);
  endtask

  task automatic run_to(input logic [63:0] target);
    while (now_i < target) idle(now_i + 64'd1);
  endtask

  task automatic settle_and_check(input string req, input logic exp_pin);
    @(posedge clk);
    #2;
    checks++;
    if (q_time.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d expected edges missing, expected 0", req, q_time.size());
      q_time.delete(); q_lvl.delete(); q_req.delete();
    end
    checks++;
    if (pin_o !== exp_pin) begin
      fails++;
      $display("FAIL %s: pin=%0b expected %0b", req, pin_o, exp_pin);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (pin_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: pin=%0b during reset, expected 0", pin_o);
    end
    @(negedge clk);
    rst = 1'b0;
    run_to(64'd10);
    settle_and_check("R1", 1'b0);

    // R2, R4, R6: basic run, then stop while high
    drive(64'd11, 1'b1, 64'd40, 1'b1, 32'd5, 1'b0, 32'd0);
    drive(64'd12, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_START);
    expect_edge(64'd40, 1'b1, "R2");
    expect_edge(64'd45, 1'b0, "R4");
    expect_edge(64'd50, 1'b1, "R4");
    expect_edge(64'd55, 1'b0, "R4");
    expect_edge(64'd60, 1'b1, "R4");
    expect_edge(64'd63, 1'b0, "R6");
    run_to(64'd62);
    drive(64'd63, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_STOP);
    run_to(64'd80);
    settle_and_check("R6", 1'b0);

    // R8 and R3: register writes alone, then start equal to and before the counter
    drive(64'd85, 1'b1, 64'd90, 1'b1, 32'd3, 1'b0, 32'd0);
    run_to(64'd89);
    settle_and_check("R8", 1'b0);
    drive(64'd90, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_START);
    run_to(64'd110);
    drive(64'd111, 1'b1, 64'd70, 1'b0, 32'd0, 1'b0, 32'd0);
    drive(64'd112, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_START);
    run_to(64'd125);
    settle_and_check("R3", 1'b0);

    // R6: start and stop in one word -> stop wins, nothing arms
    drive(64'd130, 1'b1, 64'd200, 1'b1, 32'd4, 1'b0, 32'd0);
    drive(64'd131, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_BOTH);
    run_to(64'd220);
    settle_and_check("R6", 1'b0);

    // R5: counter jump past two due times keeps the phase
    drive(64'd230, 1'b1, 64'd300, 1'b1, 32'd10, 1'b0, 32'd0);
    drive(64'd231, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_START);
    expect_edge(64'd300, 1'b1, "R2");
    expect_edge(64'd310, 1'b0, "R4");
    expect_edge(64'd320, 1'b1, "R4");
    expect_edge(64'd345, 1'b0, "R5");
    expect_edge(64'd346, 1'b1, "R5");
    expect_edge(64'd350, 1'b0, "R5");
    expect_edge(64'd360, 1'b1, "R5");
    expect_edge(64'd363, 1'b0, "R6");
    run_to(64'd323);
    idle(64'd345);
    run_to(64'd362);
    drive(64'd363, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_STOP);
    run_to(64'd366);
    settle_and_check("R5", 1'b0);

    // R7: maximum half-period, due time crosses 32 bits
    drive(64'd370, 1'b1, 64'd400, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'd0);
    drive(64'd371, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_START);
    expect_edge(64'd400, 1'b1, "R7");
    expect_edge(64'd4294967695, 1'b0, "R7");
    run_to(64'd402);
    idle(64'd4294967694);
    idle(64'd4294967695);
    idle(64'd4294967696);
    idle(64'd4294967697);
    settle_and_check("R7", 1'b0);
    drive(64'd4294967698, 1'b0, 64'd0, 1'b0, 32'd0, 1'b1, W_STOP);
    idle(64'd4294967699);
    settle_and_check("R6", 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule